// File: doc/BRIEF.md
# I2C Controller Command-Queue Engine

This block is the sequencing core of a single-master I2C controller. Software pushes command words into one queue. Each word either carries a byte to transmit or asks for one byte to be received. Two flag bits in the word can force a repeated START before the byte or a STOP after it. The engine reads the queue in order and turns each word into bus operations: START, address bytes, data bytes and STOP. Received bytes go into a separate receive FIFO, where software reads them.

The bit-level bus timing sits outside this block, in a separate bus sequencer. The engine asks it for one operation at a time over a valid/done handshake and collects the acknowledge and the received byte when the operation finishes. The block also holds the target address (7-bit or 10-bit), an enable bit and three sticky event flags: abort, command overflow and receive underflow. It reports the fill levels of both FIFOs and their depths, each depth encoded as depth minus one.

Top module: `i2c_cmdq_engine`

## Requirements
- R1: A command word is written to register 0, with bits [7:0] as the byte, bit 8 as the read request, bit 9 as the STOP request and bit 10 as the RESTART request. A write entry becomes one bus operation of kind 2 (write) carrying its byte. Entries run in the order they were queued.
- R2: A read entry ignores its byte field and becomes one operation of kind 3 (read). The byte returned by the bus sequencer is pushed into the receive FIFO. `op_nack` is high during that operation exactly when the entry also requests STOP.
- R3: A transaction starts only when the enable bit (register 3, bit 0) is set and the queue holds at least one entry. It begins with an operation of kind 0 (START). In 7-bit mode the START is followed by a write of {address[6:0], direction}, where direction is 1 for a read.
- R4: In 10-bit mode (register 1, bit 12) the address phase writes {11110, address[9:8], 0} and then address[7:0]. A read then adds a repeated START and {11110, address[9:8], 1}.
- R5: An entry whose RESTART bit is set, or whose direction differs from that of the entry before it, is preceded by a repeated START and a fresh address phase.
- R6: An entry whose STOP bit is set is followed by an operation of kind 1 (STOP), after which the engine is idle.
- R7: When the queue runs empty after an entry without STOP, the engine raises `scl_hold`, requests no operation, and continues with the next entry when one arrives.
- R8: A NACK on an address byte or on a written data byte sets the abort flag, empties the command queue and issues a STOP.
- R9: A command write to a full queue is dropped and sets the command-overflow flag.
- R10: Popping the receive FIFO while it is empty sets the receive-underflow flag and leaves the FIFO level at zero.
- R11: Writes to the target address register (register 1, address in bits [9:0]) are ignored while the engine is enabled.
- R12: `tx_level` and `rx_level` give the current entry counts. `tx_depth_m1` and `rx_depth_m1` give each depth minus one.
- R13: A read entry is not started while the receive FIFO is full. The engine holds `scl_hold` until a byte is popped.
- R14: Writing register 2 clears each set flag: bit 0 clears abort, bit 1 clears command overflow, bit 2 clears receive underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 target, 2 flag clear, 3 enable |
| reg_wdata | input | 16 | Register write data |
| rx_pop | input | 1 | Remove the head byte of the receive FIFO |
| rx_data | output | 8 | Head byte of the receive FIFO |
| rx_level | output | clog2(RX_DEPTH+1) | Receive FIFO fill level |
| tx_level | output | clog2(TX_DEPTH+1) | Command queue fill level |
| rx_depth_m1 | output | 8 | Receive FIFO depth minus one |
| tx_depth_m1 | output | 8 | Command queue depth minus one |
| abort_flag | output | 1 | Sticky NACK abort flag |
| tx_over_flag | output | 1 | Sticky command overflow flag |
| rx_under_flag | output | 1 | Sticky receive underflow flag |
| ctl_en | output | 1 | Current enable bit |
| scl_hold | output | 1 | Engine is stretching the clock and waiting |
| op_valid | output | 1 | Bus operation requested |
| op_kind | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| op_byte | output | 8 | Byte to write |
| op_nack | output | 1 | Send NACK after the byte being read |
| op_done | input | 1 | One-cycle pulse: requested operation finished |
| op_ack | input | 1 | Target acknowledged the written byte |
| op_rdata | input | 8 | Byte received by a read operation |

## Verification
The queue is driven with write-only runs, read-only runs, mixed-direction runs, and runs with an explicit RESTART bit. The recorded operation stream shows whether an address phase comes from a direction change, from the flag, or not at all. A run without STOP followed by a late entry separates a held bus from an idle one. A read run that fills the receive FIFO shows that reads stall while it is full. NACKs placed on an address byte and on a data byte check that the queue is flushed and a STOP follows. A full queue, an empty-FIFO pop and a locked address write each have one visible effect that is checked. Both addressing modes are run in both directions, so the 10-bit header bytes and the extra repeated START on reads are each checked against expected values.

// File: rtl/i2c_cq_pkg.sv
package i2c_cq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_HDR, S_ALO, S_RS10, S_HDR_RD, S_DATA, S_NEXT, S_STOP
  } seq_state_t;

  localparam int CMD_W = 11;

  typedef struct packed {
    logic       rs;
    logic       stop;
    logic       rd;
    logic [7:0] data;
  } cmd_t;

  localparam logic [1:0] REG_CMD = 2'd0;
  localparam logic [1:0] REG_TGT = 2'd1;
  localparam logic [1:0] REG_CLR = 2'd2;
  localparam logic [1:0] REG_EN  = 2'd3;
endpackage

// File: rtl/i2c_cq_fifo.sv
module i2c_cq_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_level_bound_R12: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> count == $past(count));
endmodule

// File: rtl/i2c_cq_seq.sv
module i2c_cq_seq
  import i2c_cq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       mode10,
  input  logic [9:0] tgt,
  input  logic       h_valid,
  input  cmd_t       head,
  input  logic       rx_full,
  output logic       tx_pop,
  output logic       tx_flush,
  output logic       rx_push,
  output logic       scl_hold,
  output logic       abort_evt,
  output logic       op_valid,
  output logic [1:0] op_kind,
  output logic [7:0] op_byte,
  output logic       op_nack,
  input  logic       op_done,
  input  logic       op_ack
);
  seq_state_t st;
  logic       dir_q;
  logic       step;
  logic [7:0] hdr_byte;

  assign hdr_byte = mode10 ? {5'b11110, tgt[9:8], 1'b0} : {tgt[6:0], dir_q};
  assign step     = op_valid && op_done;

  always_comb begin
    op_valid = 1'b0;
    op_kind  = OP_START;
    op_byte  = 8'h00;
    op_nack  = 1'b0;
    unique case (st)
      S_START, S_RS10: op_valid = 1'b1;
      S_HDR: begin
        op_valid = 1'b1; op_kind = OP_WRITE; op_byte = hdr_byte;
      end
      S_ALO: begin
        op_valid = 1'b1; op_kind = OP_WRITE; op_byte = tgt[7:0];
      end
      S_HDR_RD: begin
        op_valid = 1'b1; op_kind = OP_WRITE; op_byte = {5'b11110, tgt[9:8], 1'b1};
      end
      S_DATA: begin
        op_valid = !(head.rd && rx_full);
        op_kind  = head.rd ? OP_READ : OP_WRITE;
        op_byte  = head.data;
        op_nack  = head.rd && head.stop;
      end
      S_STOP: begin
        op_valid = 1'b1; op_kind = OP_STOP;
      end
      default: ;
    endcase
  end

  assign scl_hold = (st == S_NEXT && !h_valid) || (st == S_DATA && head.rd && rx_full);
  assign abort_evt = step && !op_ack &&
                     ((st == S_HDR) || (st == S_ALO) || (st == S_HDR_RD) ||
                      (st == S_DATA && !head.rd));
  assign tx_flush = abort_evt;
  assign tx_pop   = step && (st == S_DATA);
  assign rx_push  = tx_pop && head.rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      dir_q <= 1'b0;
    end else if (abort_evt) begin
      st <= S_STOP;
    end else begin
      unique case (st)
        S_IDLE: if (en && h_valid) begin
          dir_q <= head.rd;
          st    <= S_START;
        end
        S_START:  if (step) st <= S_HDR;
        S_HDR:    if (step) st <= mode10 ? S_ALO : S_DATA;
        S_ALO:    if (step) st <= dir_q ? S_RS10 : S_DATA;
        S_RS10:   if (step) st <= S_HDR_RD;
        S_HDR_RD: if (step) st <= S_DATA;
        S_DATA:   if (step) st <= head.stop ? S_STOP : S_NEXT;
        S_NEXT: if (h_valid) begin
          if (head.rs || (head.rd != dir_q)) begin
            dir_q <= head.rd;
            st    <= S_START;
          end else begin
            st <= S_DATA;
          end
        end
        S_STOP:   if (step) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assert_op_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_done) |=> (op_valid && $stable(op_kind) && $stable(op_byte)));
  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> !op_valid);
  assert_abort_stop_R8: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> (op_valid && op_kind == OP_STOP && !h_valid));
  assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !en) |=> !op_valid);
  assert_rx_room_R13: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_READ) |-> !rx_full);
endmodule

// File: rtl/i2c_cmdq_engine.sv
module i2c_cmdq_engine
  import i2c_cq_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TXL_W = $clog2(TX_DEPTH + 1),
  localparam int RXL_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic [RXL_W-1:0] rx_level,
  output logic [TXL_W-1:0] tx_level,
  output logic [7:0]       rx_depth_m1,
  output logic [7:0]       tx_depth_m1,
  output logic             abort_flag,
  output logic             tx_over_flag,
  output logic             rx_under_flag,
  output logic             ctl_en,
  output logic             scl_hold,
  output logic             op_valid,
  output logic [1:0]       op_kind,
  output logic [7:0]       op_byte,
  output logic             op_nack,
  input  logic             op_done,
  input  logic             op_ack,
  input  logic [7:0]       op_rdata
);
  logic [9:0] tgt_q;
  logic       mode10_q;
  logic       cmd_wr, clr_wr;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic       tx_pop, tx_flush, rx_push, abort_evt;
  cmd_t       head;
  logic [CMD_W-1:0] head_raw;

  assign tx_depth_m1 = 8'(TX_DEPTH - 1);
  assign rx_depth_m1 = 8'(RX_DEPTH - 1);
  assign cmd_wr = reg_wr && (reg_addr == REG_CMD);
  assign clr_wr = reg_wr && (reg_addr == REG_CLR);
  assign head   = cmd_t'(head_raw);

  i2c_cq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) i_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(cmd_wr),
    .wdata(reg_wdata[CMD_W-1:0]), .pop(tx_pop), .rdata(head_raw),
    .count(tx_level), .full(tx_full), .empty(tx_empty));

  i2c_cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .flush(1'b0), .push(rx_push),
    .wdata(op_rdata), .pop(rx_pop), .rdata(rx_data),
    .count(rx_level), .full(rx_full), .empty(rx_empty));

  i2c_cq_seq i_seq (
    .clk(clk), .rst(rst), .en(ctl_en), .mode10(mode10_q), .tgt(tgt_q),
    .h_valid(!tx_empty), .head(head), .rx_full(rx_full),
    .tx_pop(tx_pop), .tx_flush(tx_flush), .rx_push(rx_push),
    .scl_hold(scl_hold), .abort_evt(abort_evt),
    .op_valid(op_valid), .op_kind(op_kind), .op_byte(op_byte), .op_nack(op_nack),
    .op_done(op_done), .op_ack(op_ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q         <= '0;
      mode10_q      <= 1'b0;
      ctl_en        <= 1'b0;
      abort_flag    <= 1'b0;
      tx_over_flag  <= 1'b0;
      rx_under_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == REG_TGT && !ctl_en) begin
        tgt_q    <= reg_wdata[9:0];
        mode10_q <= reg_wdata[12];
      end
      if (reg_wr && reg_addr == REG_EN) ctl_en <= reg_wdata[0];
      abort_flag    <= abort_evt || (abort_flag && !(clr_wr && reg_wdata[0]));
      tx_over_flag  <= (cmd_wr && tx_full) || (tx_over_flag && !(clr_wr && reg_wdata[1]));
      rx_under_flag <= (rx_pop && rx_empty) || (rx_under_flag && !(clr_wr && reg_wdata[2]));
    end
  end

  assert_txover_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_over_flag) |-> $past(cmd_wr && tx_full));
  assert_rxunder_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_under_flag) |-> $past(rx_pop && rx_empty));
  assert_abort_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |-> $past(op_valid && op_done && !op_ack));
endmodule

// File: tb/test_i2c_cmdq_engine.sv
module test_i2c_cmdq_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic rx_pop = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] rx_level, tx_level;
  logic [7:0] rx_depth_m1, tx_depth_m1;
  logic abort_flag, tx_over_flag, rx_under_flag, ctl_en, scl_hold;
  logic op_valid, op_nack;
  logic [1:0] op_kind;
  logic [7:0] op_byte;
  logic op_done = 1'b0, op_ack = 1'b1;
  logic [7:0] op_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int log_n = 0, nack_at = -1, wait_cnt = 0, base = 0;
  int log_k [256], log_b [256], log_nk [256], log_rd [256];

  always #5 clk = ~clk;

  i2c_cmdq_engine #(.TX_DEPTH(4), .RX_DEPTH(4)) i_i2c_cmdq_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_level(rx_level), .tx_level(tx_level),
    .rx_depth_m1(rx_depth_m1), .tx_depth_m1(tx_depth_m1), .abort_flag(abort_flag),
    .tx_over_flag(tx_over_flag), .rx_under_flag(rx_under_flag), .ctl_en(ctl_en),
    .scl_hold(scl_hold), .op_valid(op_valid), .op_kind(op_kind), .op_byte(op_byte),
    .op_nack(op_nack), .op_done(op_done), .op_ack(op_ack), .op_rdata(op_rdata));

  // bus sequencer model: finishes each operation on its second low phase
  initial begin
    forever begin
      @(negedge clk);
      if (op_done) op_done = 1'b0;
      else if (op_valid) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          wait_cnt = 0;
          op_ack   = (log_n != nack_at);
          op_rdata = 8'(8'h50 + log_n);
          log_k[log_n]  = int'(op_kind);
          log_b[log_n]  = int'(op_byte);
          log_nk[log_n] = int'(op_nack);
          log_rd[log_n] = int'(op_rdata);
          log_n++;
          op_done = 1'b1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // kind 0 START, 1 STOP, 2 write, 3 read; byte < 0 skips the byte compare
  task automatic chk_op(input string tag, input int idx, input int kind, input int b);
    chk({tag, " kind"}, log_k[idx], kind);
    if (b >= 0) chk({tag, " byte"}, log_b[idx], b);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [15:0] cmd(input bit rs, input bit st, input bit rd, input logic [7:0] d);
    return {5'b0, rs, st, rd, d};
  endfunction

  task automatic pop;
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic settle;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset tx_level", int'(tx_level), 0);
    chk("R12 reset rx_level", int'(rx_level), 0);
    chk("R12 tx depth", int'(tx_depth_m1), 3);
    chk("R12 rx depth", int'(rx_depth_m1), 3);
    chk("R8 reset abort", int'(abort_flag), 0);
    chk("R3 reset op_valid", int'(op_valid), 0);

    // R3 / R1 / R6: 7-bit write run, held off while disabled
    wr(2'd1, 16'h002A);
    wr(2'd0, cmd(0, 0, 0, 8'h11));
    wr(2'd0, cmd(0, 1, 0, 8'h22));
    repeat (20) @(negedge clk);
    chk("R3 idle while disabled", log_n, 0);
    chk("R12 tx_level two", int'(tx_level), 2);
    base = log_n;
    wr(2'd3, 16'h0001);
    settle();
    chk_op("R3 start", base + 0, 0, -1);
    chk_op("R3 addr write", base + 1, 2, 8'h54);
    chk_op("R1 first byte", base + 2, 2, 8'h11);
    chk_op("R1 second byte", base + 3, 2, 8'h22);
    chk_op("R6 stop", base + 4, 1, -1);
    chk("R6 op count", log_n - base, 5);
    chk("R12 drained", int'(tx_level), 0);

    // R11: address write while enabled has no effect
    wr(2'd1, 16'h0010);
    // R2: read run
    base = log_n;
    wr(2'd0, cmd(0, 0, 1, 8'hFF));
    wr(2'd0, cmd(0, 1, 1, 8'h00));
    settle();
    chk_op("R11 addr kept", base + 1, 2, 8'h55);
    chk_op("R2 read one", base + 2, 3, -1);
    chk("R2 nack one", log_nk[base + 2], 0);
    chk_op("R2 read two", base + 3, 3, -1);
    chk("R2 nack last", log_nk[base + 3], 1);
    chk_op("R6 stop after read", base + 4, 1, -1);
    chk("R2 rx_level", int'(rx_level), 2);
    chk("R2 rx first", int'(rx_data), log_rd[base + 2]);
    pop();
    chk("R2 rx second", int'(rx_data), log_rd[base + 3]);
    pop();

    // R5: direction change forces repeated START
    base = log_n;
    wr(2'd0, cmd(0, 0, 0, 8'h33));
    wr(2'd0, cmd(0, 1, 1, 8'h00));
    settle();
    chk_op("R5 dir byte", base + 2, 2, 8'h33);
    chk_op("R5 dir restart", base + 3, 0, -1);
    chk_op("R5 dir addr", base + 4, 2, 8'h55);
    chk_op("R5 dir read", base + 5, 3, -1);
    chk("R5 dir count", log_n - base, 7);
    pop();

    // R5: explicit RESTART bit, same direction
    base = log_n;
    wr(2'd0, cmd(0, 0, 0, 8'h44));
    wr(2'd0, cmd(1, 1, 0, 8'h45));
    settle();
    chk_op("R5 flag restart", base + 3, 0, -1);
    chk_op("R5 flag addr", base + 4, 2, 8'h54);
    chk_op("R5 flag byte", base + 5, 2, 8'h45);
    chk("R5 flag count", log_n - base, 7);

    // R7: queue runs dry without STOP
    base = log_n;
    wr(2'd0, cmd(0, 0, 0, 8'h66));
    settle();
    chk("R7 hold", int'(scl_hold), 1);
    chk("R7 no ops while held", log_n - base, 3);
    wr(2'd0, cmd(0, 1, 0, 8'h77));
    settle();
    chk_op("R7 resumed byte", base + 3, 2, 8'h77);
    chk_op("R7 resumed stop", base + 4, 1, -1);
    chk("R7 hold released", int'(scl_hold), 0);

    // R13: read stalls while the receive FIFO is full
    base = log_n;
    for (int i = 0; i < 4; i++) wr(2'd0, cmd(0, i == 3, 1, 8'h00));
    settle();
    chk("R13 rx full", int'(rx_level), 4);
    base = log_n;
    wr(2'd0, cmd(0, 1, 1, 8'h00));
    settle();
    chk("R13 stalled", log_n - base, 2);
    chk("R13 hold", int'(scl_hold), 1);
    chk("R13 oldest byte", int'(rx_data), log_rd[base - 5]);
    pop();
    settle();
    chk_op("R13 read after pop", base + 2, 3, -1);
    chk("R13 rx full again", int'(rx_level), 4);
    for (int i = 0; i < 4; i++) pop();

    // R8: NACK on a data byte
    wr(2'd3, 16'h0000);
    wr(2'd0, cmd(0, 0, 0, 8'hA1));
    wr(2'd0, cmd(0, 0, 0, 8'hA2));
    wr(2'd0, cmd(0, 1, 0, 8'hA3));
    base = log_n;
    nack_at = base + 3;
    wr(2'd3, 16'h0001);
    settle();
    chk_op("R8 stop after data nack", base + 4, 1, -1);
    chk("R8 count data nack", log_n - base, 5);
    chk("R8 abort flag", int'(abort_flag), 1);
    chk("R8 queue flushed", int'(tx_level), 0);
    wr(2'd2, 16'h0001);
    chk("R14 abort cleared", int'(abort_flag), 0);

    // R8: NACK on the address byte
    wr(2'd3, 16'h0000);
    wr(2'd0, cmd(0, 1, 0, 8'hB1));
    base = log_n;
    nack_at = base + 1;
    wr(2'd3, 16'h0001);
    settle();
    chk_op("R8 stop after addr nack", base + 2, 1, -1);
    chk("R8 count addr nack", log_n - base, 3);
    chk("R8 abort addr", int'(abort_flag), 1);
    nack_at = -1;
    wr(2'd2, 16'h0001);

    // R9: overflow of the command queue
    wr(2'd3, 16'h0000);
    for (int i = 0; i < 5; i++) wr(2'd0, cmd(0, i == 3, 0, 8'(8'hC0 + i)));
    chk("R9 level full", int'(tx_level), 4);
    chk("R9 overflow flag", int'(tx_over_flag), 1);
    wr(2'd2, 16'h0002);
    chk("R14 overflow cleared", int'(tx_over_flag), 0);
    base = log_n;
    wr(2'd3, 16'h0001);
    settle();
    chk_op("R9 last kept byte", base + 5, 2, 8'hC3);
    chk_op("R9 dropped entry absent", base + 6, 1, -1);
    chk("R9 count", log_n - base, 7);

    // R10: underflow
    pop();
    chk("R10 underflow flag", int'(rx_under_flag), 1);
    chk("R10 level stays", int'(rx_level), 0);
    wr(2'd2, 16'h0004);
    chk("R14 underflow cleared", int'(rx_under_flag), 0);

    // R4: 10-bit addressing, write then read
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h12A5);
    wr(2'd0, cmd(0, 1, 0, 8'h3C));
    base = log_n;
    wr(2'd3, 16'h0001);
    settle();
    chk_op("R4 hdr write", base + 1, 2, 8'hF4);
    chk_op("R4 low addr", base + 2, 2, 8'hA5);
    chk_op("R4 data", base + 3, 2, 8'h3C);
    chk_op("R4 stop", base + 4, 1, -1);
    base = log_n;
    wr(2'd0, cmd(0, 1, 1, 8'h00));
    settle();
    chk_op("R4 rd hdr", base + 1, 2, 8'hF4);
    chk_op("R4 rd low", base + 2, 2, 8'hA5);
    chk_op("R4 rd restart", base + 3, 0, -1);
    chk_op("R4 rd hdr read", base + 4, 2, 8'hF5);
    chk_op("R4 rd byte", base + 5, 3, -1);
    chk_op("R4 rd stop", base + 6, 1, -1);
    chk("R4 rd data", int'(rx_data), log_rd[base + 5]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule